// File: doc/BRIEF.md
# CPU Bus Memory, Port and Interrupt Adapter

This block sits on the system side of an 8-bit processor whose bus uses one master strobe per access. With the strobe high, the block reads the access type, direction, opcode-fetch marker and 16-bit address. Memory accesses go to an on-chip synchronous RAM. IO accesses go to a bank of 256 byte-wide port registers, indexed by the low address byte. Read data comes back registered, so it is stable for the whole cycle after the strobed cycle, which is where the processor samples it.

The block also drives the processor's interrupt request. Single-cycle pulses on eight request lines set pending bits, and the request output is high while any bit is pending. When the processor raises its acknowledge output, the block takes the lowest-numbered pending request and holds that choice. It then substitutes instruction bytes on memory reads. In restart mode it supplies one opcode that encodes the request number. In call mode it supplies a call opcode and then the two bytes of a target address derived from that number. Data reads that are not substituted, and all writes, still reach RAM. When acknowledge falls, the chosen pending bit is cleared.

Top module: `cpu_bus_adapter`

## Requirements
- R1: While `busEn` is low, no RAM or port write happens, and `cpuRdData` keeps its value whatever `rdStb`, `wrStb`, `ioSel` or `addrIn` do.
- R2: A write commits `cpuWrData` on the edge where `busEn` and `wrStb` are both high. A read strobed on edge N presents its data on `cpuRdData` from edge N until the next read edge, so a read that directly follows a write returns the new byte.
- R3: RAM is indexed by the low `RAM_AW` address bits (default 10). Higher address bits are ignored, so 0x0405 and 0x0005 name the same byte.
- R4: With `ioSel` high, accesses go to port register `addrIn[7:0]`, which is separate from RAM. An IO write never changes RAM, and a memory write never changes a port.
- R5: In restart mode (`callMode`=0), while `ackActive` is high, the first memory read with `opFetch` high returns 0xC7 OR (n shifted left by 3), where n is the chosen request number. That byte is not taken from RAM.
- R6: In call mode (`callMode`=1), while `ackActive` is high, the opcode fetch returns 0xCD. The next two memory reads return the target low byte and then the high byte. The target is {`callBase[15:6]`, n, 3'b000}.
- R7: While `ackActive` is high, a memory read made before the injected opcode fetch, or after the injected bytes are used up, returns RAM contents. Writes made during acknowledge update RAM.
- R8: A one-cycle pulse on `reqIn[i]` sets pending bit i. `irqOut` is high from the following cycle for as long as any bit is pending.
- R9: On the rising edge of `ackActive`, the lowest-numbered pending request is chosen. The choice does not change for the rest of the acknowledge, even if new requests arrive.
- R10: When `ackActive` falls, only the chosen request's pending bit is cleared. `irqOut` stays high if other bits are still pending.
- R11: A synchronous reset clears all pending bits, `cpuRdData` and the substitution state. RAM and port contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| busEn | input | 1 | Master access strobe from the processor |
| ioSel | input | 1 | Access is to IO space, not memory |
| rdStb | input | 1 | Read access |
| wrStb | input | 1 | Write access |
| opFetch | input | 1 | Access is an opcode fetch |
| ackActive | input | 1 | Processor interrupt acknowledge |
| addrIn | input | 16 | Access address |
| cpuWrData | input | 8 | Write data from the processor |
| cpuRdData | output | 8 | Registered read data to the processor |
| irqOut | output | 1 | Interrupt request to the processor |
| reqIn | input | 8 | Request pulses, one per source |
| callMode | input | 1 | 1: inject a call with a target address; 0: inject a restart opcode |
| callBase | input | 16 | Upper bits of the call target |

## Verification
The assertions assume a well-formed processor. Read and write are never strobed together, and an IO access always has a zero upper address byte. `callMode` and `callBase` are assumed to stay fixed during an acknowledge. The stimulus changes inputs only at falling edges. It keeps every IO address below 0x0100 and strobes exactly one direction per access. It sets the mode before raising acknowledge, so none of these assumptions is violated.

// File: rtl/cpu_bus_adapter_pkg.sv
package cpu_bus_adapter_pkg;
  typedef struct packed {
    logic       memWr;
    logic       memRd;
    logic       ioWr;
    logic       ioRd;
    logic       inject;
    logic [7:0] injByte;
  } busStrobe_t;
endpackage

// File: rtl/cpu_bus_adapter_ctrl.sv
module cpu_bus_adapter_ctrl
  import cpu_bus_adapter_pkg::*;
#(
  parameter int NREQ = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busEn,
  input  logic             ioSel,
  input  logic             rdStb,
  input  logic             wrStb,
  input  logic             opFetch,
  input  logic             ackActive,
  input  logic [15:0]      addrIn,
  input  logic [NREQ-1:0]  reqIn,
  input  logic             callMode,
  input  logic [15:0]      callBase,
  output busStrobe_t       strobes,
  output logic             irqOut
);
  localparam int NUM_W = $clog2(NREQ);
  localparam int BASE_LO = NUM_W + 3;

  logic [NREQ-1:0]  pending;
  logic [NREQ-1:0]  pendingNext;
  logic             ackPrev;
  logic [NUM_W-1:0] latchNum;
  logic [NUM_W-1:0] pickNum;
  logic [NUM_W-1:0] curNum;
  logic [1:0]       injCnt;
  logic [1:0]       injLen;
  logic [15:0]      callTarget;
  logic             memRead;
  logic             doInject;

  // lowest-numbered pending request wins
  always_comb begin
    pickNum = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (pending[i]) pickNum = NUM_W'(i);
    end
  end

  assign curNum     = (ackActive && !ackPrev) ? pickNum : latchNum;
  assign callTarget = {callBase[15:BASE_LO], curNum, 3'b000};
  assign injLen     = callMode ? 2'd3 : 2'd1;
  assign memRead    = busEn && !ioSel && rdStb;
  assign doInject   = memRead && ackActive &&
                      ((injCnt == 2'd0) ? opFetch : (injCnt < injLen));

  always_comb begin
    strobes.memWr  = busEn && !ioSel && wrStb;
    strobes.memRd  = memRead && !doInject;
    strobes.ioWr   = busEn && ioSel && wrStb;
    strobes.ioRd   = busEn && ioSel && rdStb;
    strobes.inject = doInject;
    case (injCnt)
      2'd0:    strobes.injByte = callMode ? 8'hCD
                                          : (8'hC7 | {{(5-NUM_W){1'b0}}, curNum, 3'b000});
      2'd1:    strobes.injByte = callTarget[7:0];
      default: strobes.injByte = callTarget[15:8];
    endcase
  end

  always_comb begin
    pendingNext = pending;
    if (ackPrev && !ackActive) pendingNext[latchNum] = 1'b0;
    pendingNext = pendingNext | reqIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= '0;
      ackPrev  <= 1'b0;
      latchNum <= '0;
      injCnt   <= 2'd0;
    end else begin
      pending  <= pendingNext;
      ackPrev  <= ackActive;
      latchNum <= curNum;
      if (!ackActive)    injCnt <= 2'd0;
      else if (doInject) injCnt <= injCnt + 2'd1;
    end
  end

  assign irqOut = |pending;

  // input assumptions
  p_rdwr_excl_r2: assert property (@(posedge clk) disable iff (rst)
    busEn |-> !(rdStb && wrStb));
  p_io_high_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (busEn && ioSel) |-> (addrIn[15:8] == 8'h00));
  // request capture
  p_pend_set_r8: assert property (@(posedge clk) disable iff (rst)
    (|reqIn) |=> ((pending & $past(reqIn)) == $past(reqIn)));
  // chosen bit dropped on acknowledge fall
  p_pend_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (ackPrev && !ackActive && !reqIn[latchNum]) |=> !pending[$past(latchNum)]);
  // choice held during acknowledge
  p_num_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ackPrev && ackActive) |-> (curNum == latchNum));
  // substitution state restarts outside acknowledge
  p_cnt_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !ackActive |=> (injCnt == 2'd0));
endmodule

// File: rtl/cpu_bus_adapter_dpath.sv
module cpu_bus_adapter_dpath
  import cpu_bus_adapter_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  busStrobe_t  strobes,
  input  logic [15:0] addrIn,
  input  logic [7:0]  cpuWrData,
  output logic [7:0]  cpuRdData
);
  localparam int RAM_DEPTH = 1 << RAM_AW;
  localparam int PORTS     = 256;

  logic [7:0] ram   [RAM_DEPTH];
  logic [7:0] ports [PORTS];
  logic [RAM_AW-1:0] ramIdx;
  logic [7:0]        portIdx;

  assign ramIdx  = addrIn[RAM_AW-1:0];
  assign portIdx = addrIn[7:0];

  always_ff @(posedge clk) begin
    if (strobes.memWr) ram[ramIdx] <= cpuWrData;
    if (strobes.ioWr)  ports[portIdx] <= cpuWrData;
  end

  always_ff @(posedge clk) begin
    if (rst)                 cpuRdData <= 8'h00;
    else if (strobes.inject) cpuRdData <= strobes.injByte;
    else if (strobes.memRd)  cpuRdData <= ram[ramIdx];
    else if (strobes.ioRd)   cpuRdData <= ports[portIdx];
  end

  p_src_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.inject, strobes.memRd, strobes.ioRd}));
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !(strobes.inject || strobes.memRd || strobes.ioRd) |=> $stable(cpuRdData));
  p_wr_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(strobes.memWr && strobes.ioWr));
endmodule

// File: rtl/cpu_bus_adapter.sv
module cpu_bus_adapter
  import cpu_bus_adapter_pkg::*;
#(
  parameter int RAM_AW = 10,
  parameter int NREQ   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            busEn,
  input  logic            ioSel,
  input  logic            rdStb,
  input  logic            wrStb,
  input  logic            opFetch,
  input  logic            ackActive,
  input  logic [15:0]     addrIn,
  input  logic [7:0]      cpuWrData,
  output logic [7:0]      cpuRdData,
  output logic            irqOut,
  input  logic [NREQ-1:0] reqIn,
  input  logic            callMode,
  input  logic [15:0]     callBase
);
  busStrobe_t strobes;

  cpu_bus_adapter_ctrl #(.NREQ(NREQ)) u_ctrl (
    .clk(clk), .rst(rst), .busEn(busEn), .ioSel(ioSel), .rdStb(rdStb),
    .wrStb(wrStb), .opFetch(opFetch), .ackActive(ackActive), .addrIn(addrIn),
    .reqIn(reqIn), .callMode(callMode), .callBase(callBase),
    .strobes(strobes), .irqOut(irqOut)
  );

  cpu_bus_adapter_dpath #(.RAM_AW(RAM_AW)) u_dpath (
    .clk(clk), .rst(rst), .strobes(strobes), .addrIn(addrIn),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData)
  );
endmodule

// File: tb/sim_cpu_bus_adapter.sv
`timescale 1ns/1ps
module sim_cpu_bus_adapter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busEn = 0, ioSel = 0, rdStb = 0, wrStb = 0, opFetch = 0, ackActive = 0;
  logic [15:0] addrIn = '0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  cpuRdData;
  logic        irqOut;
  logic [7:0]  reqIn = '0;
  logic        callMode = 0;
  logic [15:0] callBase = '0;

  int checks = 0;
  int failures = 0;
  bit modelOn = 0;

  always #2.5 clk = ~clk;

  cpu_bus_adapter u0 (
    .clk(clk), .rst(rst), .busEn(busEn), .ioSel(ioSel), .rdStb(rdStb),
    .wrStb(wrStb), .opFetch(opFetch), .ackActive(ackActive), .addrIn(addrIn),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .irqOut(irqOut),
    .reqIn(reqIn), .callMode(callMode), .callBase(callBase)
  );

  // behavioural reference model
  byte unsigned refMem [int];
  byte unsigned refPort [int];
  int mRd = 0, mPend = 0, mCnt = 0, mNum = 0;
  bit mAckPrev = 0;

  function automatic int lowestBit(int v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic int memAt(int a);
    return refMem.exists(a % 1024) ? int'(refMem[a % 1024]) : -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mRd = 0; mPend = 0; mCnt = 0; mNum = 0; mAckPrev = 0;
    end else begin
      int len, tgt;
      if (ackActive && !mAckPrev) mNum = lowestBit(mPend);
      len = callMode ? 3 : 1;
      tgt = (int'(callBase) & 16'hFFC0) + mNum * 8;
      if (busEn && rdStb) begin
        if (ioSel) mRd = refPort.exists(addrIn[7:0]) ? int'(refPort[addrIn[7:0]]) : -1;
        else if (ackActive && ((mCnt == 0 && opFetch) || (mCnt > 0 && mCnt < len))) begin
          if (mCnt == 0) mRd = callMode ? 8'hCD : (8'hC7 | (mNum * 8));
          else if (mCnt == 1) mRd = tgt % 256;
          else mRd = tgt / 256;
          mCnt++;
        end else mRd = memAt(addrIn);
      end
      if (busEn && wrStb) begin
        if (ioSel) refPort[addrIn[7:0]] = cpuWrData;
        else refMem[addrIn % 1024] = cpuWrData;
      end
      if (!ackActive) mCnt = 0;
      if (mAckPrev && !ackActive) mPend = mPend & ~(1 << mNum);
      mPend = mPend | reqIn;
      mAckPrev = ackActive;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (modelOn) begin
      checks++;
      if (mRd >= 0 && cpuRdData !== mRd[7:0]) begin
        failures++;
        $display("FAIL R2 R5 R6 R7 model read data: actual=%h expected=%h", cpuRdData, mRd[7:0]);
      end
      checks++;
      if (irqOut !== (mPend != 0)) begin
        failures++;
        $display("FAIL R8 R10 model request: actual=%b expected=%b", irqOut, mPend != 0);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(bit v, bit io, bit rd, bit wr, bit f, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    busEn = v; ioSel = io; rdStb = rd; wrStb = wr; opFetch = f; addrIn = a; cpuWrData = d;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 16'h0, 8'h0);
  endtask

  task automatic pulseReq(logic [7:0] r);
    @(negedge clk); reqIn = r;
    @(negedge clk); reqIn = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 reset read data", cpuRdData, 8'h00);
    chk("R11 reset request", irqOut, 0);
    modelOn = 1;

    // R2 back-to-back writes and reads
    drive(1, 0, 0, 1, 0, 16'h0010, 8'hA5);
    drive(1, 0, 0, 1, 0, 16'h0011, 8'h3C);
    drive(1, 0, 1, 0, 0, 16'h0010, 8'h00);
    drive(1, 0, 1, 0, 0, 16'h0011, 8'h00);
    chk("R2 read after write", cpuRdData, 8'hA5);
    idle();
    chk("R2 second read", cpuRdData, 8'h3C);
    drive(1, 0, 0, 1, 0, 16'h0012, 8'h81);
    drive(1, 0, 1, 0, 0, 16'h0012, 8'h00);
    idle();
    chk("R2 read directly after write", cpuRdData, 8'h81);

    // R1 strobes ignored without busEn
    drive(0, 0, 0, 1, 0, 16'h0010, 8'hFF);
    drive(0, 0, 1, 0, 0, 16'h0011, 8'h00);
    idle();
    chk("R1 read data held", cpuRdData, 8'h81);
    drive(1, 0, 1, 0, 0, 16'h0010, 8'h00);
    idle();
    chk("R1 no write without strobe", cpuRdData, 8'hA5);

    // R3 aliasing
    drive(1, 0, 0, 1, 0, 16'h0405, 8'h77);
    drive(1, 0, 1, 0, 0, 16'h0005, 8'h00);
    idle();
    chk("R3 alias read", cpuRdData, 8'h77);

    // R4 IO space
    drive(1, 1, 0, 1, 0, 16'h0010, 8'h5A);
    drive(1, 0, 1, 0, 0, 16'h0010, 8'h00);
    drive(1, 1, 1, 0, 0, 16'h0010, 8'h00);
    chk("R4 memory untouched by IO write", cpuRdData, 8'hA5);
    idle();
    chk("R4 port read", cpuRdData, 8'h5A);

    // R8 requests 2 and 5
    pulseReq(8'b0010_0100);
    chk("R8 request raised", irqOut, 1);

    // R5/R7 restart injection, choice n=2
    callMode = 0;
    @(negedge clk); ackActive = 1;
    drive(1, 0, 1, 0, 0, 16'h0010, 8'h00);
    drive(1, 0, 1, 0, 1, 16'h0000, 8'h00);
    chk("R7 data read before fetch", cpuRdData, 8'hA5);
    drive(1, 0, 1, 0, 0, 16'h0011, 8'h00);
    chk("R5 restart opcode", cpuRdData, 8'hD7);
    idle();
    chk("R7 read after injection", cpuRdData, 8'h3C);
    reqIn = 8'b0000_0001;
    @(negedge clk); reqIn = '0; ackActive = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 request remains", irqOut, 1);

    // R6 call injection, n=0 (R9 lowest of 0 and 5)
    callMode = 1; callBase = 16'h12C0;
    @(negedge clk); ackActive = 1;
    drive(1, 0, 1, 0, 1, 16'h0000, 8'h00);
    drive(1, 0, 1, 0, 0, 16'h0001, 8'h00);
    chk("R6 call opcode", cpuRdData, 8'hCD);
    drive(1, 0, 1, 0, 0, 16'h0002, 8'h00);
    chk("R6 R9 target low", cpuRdData, 8'hC0);
    drive(1, 0, 0, 1, 0, 16'h0020, 8'h99);
    chk("R6 target high", cpuRdData, 8'h12);
    drive(1, 0, 1, 0, 0, 16'h0020, 8'h00);
    idle();
    chk("R7 write during acknowledge", cpuRdData, 8'h99);
    ackActive = 0;
    @(negedge clk); @(negedge clk);

    // R9 choice held: n=5, new request 3 mid-acknowledge
    callMode = 0;
    @(negedge clk); ackActive = 1;
    reqIn = 8'b0000_1000;
    drive(1, 0, 1, 0, 1, 16'h0000, 8'h00);
    reqIn = '0;
    idle();
    chk("R9 restart n=5 held", cpuRdData, 8'hEF);
    ackActive = 0;
    @(negedge clk); @(negedge clk);
    chk("R10 request 3 still pending", irqOut, 1);
    @(negedge clk); ackActive = 1;
    drive(1, 0, 1, 0, 1, 16'h0000, 8'h00);
    idle();
    chk("R5 restart n=3", cpuRdData, 8'hDF);
    ackActive = 0;
    @(negedge clk); @(negedge clk);
    chk("R10 all cleared", irqOut, 0);

    // R11 reset keeps RAM, clears state
    pulseReq(8'h40);
    modelOn = 0;
    rst = 1; @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R11 pending cleared", irqOut, 0);
    chk("R11 read data cleared", cpuRdData, 8'h00);
    drive(1, 0, 1, 0, 0, 16'h0020, 8'h00);
    idle();
    chk("R11 RAM retained", cpuRdData, 8'h99);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule